// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counter timebase. A free-running tick input first passes through a prescaler that divides it by 1, 4 or 16. Each prescaled tick advances the counter. When the counter equals the period register, the counter returns to zero instead of counting up, and a one-cycle timebase pulse is emitted. A waveform generator can use that pulse as its cycle boundary.

The period-match events also feed a postscaler. The postscaler raises a sticky interrupt flag once for every N matches, where N is 1 to 16. A small register port gives read and write access to three registers: the counter, the period and a control word. The control word holds the run bit, the prescale select and the postscale select. The flag is cleared through a dedicated input, and the interrupt output is the flag gated by an enable input.

Any write to the counter or to the control word restarts both the prescaler and the postscaler. A control write leaves the counter value untouched.

Top module: `pmt_timer`

## Requirements
- R1: After reset the counter reads 0, the period reads all ones, the control word reads 0, and `flag_o`, `irq_o` and `match_o` are low.
- R2: The register address map is: 0 for the counter, 1 for the period, 2 for the control word and 3 for nothing (reads 0). A write with `bus_wr_i` high takes effect at the next clock edge. `bus_rdata_o` shows the addressed register combinationally. Control bit 7 reads as 0.
- R3: The prescale select sits in control bits [1:0]: 00 divides by 1, 01 by 4, and 10 or 11 by 16. Only cycles with `tick_i` high count toward a prescaled tick.
- R4: Control bit 2 is the run bit. While it is 0, the counter and the prescaler hold their values.
- R5: On a prescaled tick where the counter equals the period, the counter becomes 0 instead of counting up. `match_o` is then high for exactly the one cycle after that edge.
- R6: With postscale field k in control bits [6:3], the flag is set by every (k+1)-th match. It rises at the same edge that makes `match_o` high.
- R7: The flag stays set until `flag_clr_i` is sampled high. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.
- R9: A write to the counter or to the control word restarts the prescaler and the postscaler from zero.
- R10: A write to the control word does not change the counter value.
- R11: A counter write takes priority over a count or reload in the same cycle. A period write is used from the next comparison on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Free-running count enable before prescaling |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | CNT_W | Register write data |
| bus_rdata_o | output | CNT_W | Read data of the addressed register |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| match_o | output | 1 | Timebase pulse, one cycle per period match |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Flag gated by the enable |

## Verification
Two pairs of events can land on the same edge. The first pair is a bus write to the counter and a prescaled count. The bench provokes it by writing the counter while the timer runs at divide-by-1 with the tick held high. It then requires the written value to appear unchanged, with the count resuming one cycle later. The second pair is a flag set and a flag clear. The bench holds `flag_clr_i` high while a match sets the flag every cycle, and requires the flag to stay high until the timer is stopped.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  localparam logic [1:0] ADDR_CNT = 2'd0;
  localparam logic [1:0] ADDR_PER = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  typedef struct packed {
    logic [POST_W-1:0] post;
    logic              run;
    logic [1:0]        pre;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // last prescaler state before a prescaled tick: divide-by-(value+1)
  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRE_W'(0);
      2'b01:   return PRE_W'(3);
      default: return PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler import pmt_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [1:0]       sel_i,
  output logic             ptick_o,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == pre_last(sel_i));
  assign ptick_o = run_i && !clr_i && at_last;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = step_i && !wr_i && (cnt_q == period_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (step_i)  cnt_q <= (cnt_q == period_i) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler import pmt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              match_i,
  input  logic [POST_W-1:0] ratio_i,
  output logic              evt_o,
  output logic [POST_W-1:0] cnt_o
);
  logic [POST_W-1:0] cnt_q;
  logic              at_last;

  assign at_last = (cnt_q == ratio_i);
  assign evt_o   = match_i && !clr_i && at_last;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (match_i)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer import pmt_pkg::*; #(
  parameter int               CNT_W      = 8,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic             match_o,
  output logic             flag_o,
  output logic             irq_o
);
  ctl_t              ctl_q;
  logic [CNT_W-1:0]  period_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q;
  logic              match_q;

  // named internal events
  logic              wr_cnt, wr_per, wr_ctl;
  logic              scale_clr;
  logic              run_on;
  logic              ptick;
  logic              hit;
  logic              post_evt;
  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;

  assign wr_cnt    = bus_wr_i && (bus_addr_i == ADDR_CNT);
  assign wr_per    = bus_wr_i && (bus_addr_i == ADDR_PER);
  assign wr_ctl    = bus_wr_i && (bus_addr_i == ADDR_CTL);
  assign scale_clr = wr_cnt || wr_ctl;
  assign run_on    = ctl_q.run;

  pmt_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (scale_clr),
    .run_i   (run_on && tick_i),
    .sel_i   (ctl_q.pre),
    .ptick_o (ptick),
    .cnt_o   (pre_cnt)
  );

  pmt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_cnt),
    .wdata_i  (bus_wdata_i),
    .step_i   (ptick),
    .period_i (period_q),
    .cnt_o    (cnt_q),
    .hit_o    (hit)
  );

  pmt_postscaler u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (scale_clr),
    .match_i (hit),
    .ratio_i (ctl_q.post),
    .evt_o   (post_evt),
    .cnt_o   (post_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      period_q <= PERIOD_RST;
      flag_q   <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q    <= ctl_t'(bus_wdata_i[CTL_W-1:0]);
      if (wr_per) period_q <= bus_wdata_i;
      if (post_evt)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      match_q <= hit;
    end
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_CNT: bus_rdata_o = cnt_q;
      ADDR_PER: bus_rdata_o = period_q;
      ADDR_CTL: bus_rdata_o = CNT_W'(ctl_q);
      default:  bus_rdata_o = '0;
    endcase
  end

  assign match_o = match_q;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q && irq_en_i;
endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk import pmt_pkg::*; #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic             match_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_on,
  input logic             wr_cnt,
  input logic             wr_ctl,
  input logic [1:0]       pre_sel,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [POST_W-1:0] post_cnt
);
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last(pre_sel));

  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_on && !wr_cnt) |=> $stable(cnt_q));

  a_r5_match_reload: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (cnt_q == '0));

  a_r6_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> match_o);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

  a_r8_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && irq_en_i));

  a_r9_scale_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt || wr_ctl) |=> (pre_cnt == '0 && post_cnt == '0));

  a_r10_ctl_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wr_cnt) |=> $stable(cnt_q));
endmodule

bind pmt_timer pmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_en_i   (irq_en_i),
  .flag_clr_i (flag_clr_i),
  .match_o    (match_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .cnt_q      (cnt_q),
  .run_on     (run_on),
  .wr_cnt     (wr_cnt),
  .wr_ctl     (wr_ctl),
  .pre_sel    (ctl_q.pre),
  .pre_cnt    (pre_cnt),
  .post_cnt   (post_cnt)
);

// File: tb/sim_pmt_timer.sv
`timescale 1ns/1ps
module sim_pmt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;
  logic       irq_en_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       match_o, flag_o, irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmt_timer #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .match_o(match_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr_i = a;
    #1;
    v = int'(bus_rdata_o);
  endtask

  function automatic int div_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, n, first, m, N;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 counter", v, 0);
    rd(2'd1, v); chk("R1 period", v, 255);
    rd(2'd2, v); chk("R1 control", v, 0);
    chk("R1 flag", int'(flag_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 match", int'(match_o), 0);

    // R2 register access
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 period rw", v, 8'hA5);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 ctl bit7 zero", v, 8'h7F);
    wr(2'd2, 8'h00);
    rd(2'd3, v); chk("R2 unused addr", v, 0);
    wr(2'd0, 8'h5A); rd(2'd0, v); chk("R2 counter rw", v, 8'h5A);

    // R4 hold while run bit clear
    tick_i = 1'b1;
    wr(2'd0, 8'h20);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R4 hold when off", v, 8'h20);

    // R3 tick gating: divide-by-1 running, tick low keeps counter
    wr(2'd1, 8'hFF);
    tick_i = 1'b0;
    wr(2'd2, 8'h04);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk("R3 no tick no count", v, 8'h20);
    tick_i = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R3 tick counts", v, 8'h21);

    // R11 counter write beats increment (div1, tick high)
    wr(2'd0, 8'h10);
    rd(2'd0, v); chk("R11 write priority", v, 8'h10);
    @(negedge clk);
    rd(2'd0, v); chk("R11 count resumes", v, 8'h11);

    // R10 control write keeps counter
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h37);
    wr(2'd2, 8'h06);
    rd(2'd0, v); chk("R10 ctl write keeps counter", v, 8'h37);

    // R9 counter write restarts prescaler (div16)
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h05);
    n = 0;
    do begin
      @(negedge clk); n++; rd(2'd0, v);
    end while (v != 8'h06 && n < 40);
    chk("R9 counter write restarts prescale", n, 16);

    // R9 control write restarts prescaler
    repeat (10) @(negedge clk);
    rd(2'd0, v);
    m = v;
    wr(2'd2, 8'h06);
    n = 0;
    do begin
      @(negedge clk); n++; rd(2'd0, v);
    end while (v == m && n < 40);
    chk("R9 ctl write restarts prescale", n, 16);

    // R11 period write used at next comparison
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h04);
    first = -1;
    for (int i = 0; i <= 5; i++) begin
      if (i > 0) @(negedge clk);
      if (match_o && first < 0) first = i;
    end
    chk("R11 new period match", first, 3);

    // R3 R5 R6 sweep over prescale, period, postscale
    for (int sel = 0; sel < 4; sel++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int ki = 0; ki < 3; ki++) begin
          int P, k;
          P = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
          k = (ki == 0) ? 0 : (ki == 1) ? 1 : 3;
          N = div_of(sel) * (P + 1) * (k + 1);
          wr(2'd2, 8'h00);
          wr(2'd0, 8'h00);
          wr(2'd1, 8'(P));
          @(negedge clk); flag_clr_i = 1'b1;
          @(negedge clk); flag_clr_i = 1'b0;
          wr(2'd2, 8'((k << 3) | 4 | sel));
          first = -1; m = 0;
          for (int i = 0; i <= N; i++) begin
            if (i > 0) @(negedge clk);
            if (match_o) m++;
            if (flag_o && first < 0) first = i;
          end
          chk($sformatf("R6 R3 flag edge sel%0d P%0d k%0d", sel, P, k), first, N);
          chk($sformatf("R5 match count sel%0d P%0d k%0d", sel, P, k), m, k + 1);
        end
      end
    end

    // R7 sticky flag, R8 gating
    wr(2'd2, 8'h00);
    repeat (20) @(negedge clk);
    chk("R7 flag sticky", int'(flag_o), 1);
    irq_en_i = 1'b0; #1;
    chk("R8 irq masked", int'(irq_o), 0);
    irq_en_i = 1'b1; #1;
    chk("R8 irq raised", int'(irq_o), 1);
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    chk("R7 flag cleared", int'(flag_o), 0);
    chk("R8 irq low without flag", int'(irq_o), 0);
    irq_en_i = 1'b0;

    // R7 set wins over clear (match every cycle, clear held)
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    flag_clr_i = 1'b1;
    wr(2'd2, 8'h04);
    repeat (3) @(negedge clk);
    m = 0;
    for (int i = 0; i < 6; i++) begin
      if (!flag_o) m++;
      @(negedge clk);
    end
    chk("R7 set beats clear", m, 0);
    wr(2'd2, 8'h00);
    @(negedge clk);
    chk("R7 clear after stop", int'(flag_o), 0);
    flag_clr_i = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule